// File: doc/BRIEF.md
# Strobed BCD Seven-Segment Decoder with LCD Polarity Drive

This block turns a 4-bit code into the seven segment lines of one display digit. A strobe-controlled holding register sits in front of the decoder. While the strobe is high, the register takes a new code on every clock. While the strobe is low, the digit stays frozen whatever arrives on the code pins. All sixteen code values produce a distinct glyph. Codes 0 to 9 show the decimal digits, and the six upper codes show L, P, H, A, a dash and a blank.

A display-frequency input sets the polarity of the segment lines. Each segment line is the selected/unselected state of that segment XORed with the display-frequency level. The input can be held low, to drive selected segments high. It can be held high, to drive selected segments low. It can also toggle as a square wave, to give the AC drive a liquid-crystal panel needs.

A copy of the display-frequency signal leaves the block on its own pin, for the panel's common electrode. This copy passes through the same register stage as the segment lines, so the two stay phase-aligned. Level shifting and pad drive are left to the pad ring.

Top module: `seg7_lcd_decoder`

## Requirements
- R1: Codes 0..9 give these seg_out patterns, where bit 0 is segment a and bit 6 is segment g: 0=7'h3F, 1=7'h06, 2=7'h5B, 3=7'h4F, 4=7'h66, 5=7'h6D, 6=7'h7D, 7=7'h07, 8=7'h7F, 9=7'h6F (display-frequency low).
- R2: Codes 10..15 give L=7'h38, P=7'h73, H=7'h76, A=7'h77, dash=7'h40 and blank=7'h00, in that order. All sixteen patterns differ from each other.
- R3: While strobe is high, the code on code_in is captured at each rising clock edge. The captured glyph reaches seg_out at the following edge, which is two edges after the code is applied.
- R4: While strobe is low, the held code does not change and code_in has no effect on seg_out.
- R5: With df_in held low, a selected segment drives 1 and an unselected segment drives 0.
- R6: With df_in held high, a selected segment drives 0 and an unselected segment drives 1.
- R7: When df_in toggles, every segment line inverts at the edge after each change. Selected segments are then in antiphase with com_out and unselected segments are in phase with it.
- R8: com_out equals df_in delayed by one clock edge, through the same stage as the segment lines.
- R9: Reset is synchronous and active low. It sets the held code to 15 (blank) and clears seg_out and com_out to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| code_in | input | 4 | Code to be displayed |
| strobe | input | 1 | High: capture code_in; low: hold the previous code |
| df_in | input | 1 | Display-frequency level or square wave |
| seg_out | output | 7 | Segment lines, bit 0 = a through bit 6 = g |
| com_out | output | 1 | Registered copy of df_in for the common electrode |

## Verification
Two events can land on the same edge: the holding register captures a new code, and the output stage applies a new display-frequency polarity to the glyph that was held before. The bench provokes this by raising strobe with a new code in the same cycle that df_in flips. It then expects two results in turn. On the first edge, the old glyph appears inverted while com_out follows the new df_in level. On the next edge, the new glyph appears at the polarity df_in has at that moment.

// File: rtl/seg7_lcd_pkg.sv
// Package: shared widths, types and constants for the segment decoder.
// Assumes a single-digit display with 4-bit codes and 7 segments.
package seg7_lcd_pkg;
    localparam int CODE_W     = 4;
    localparam int SEG_N      = 7;
    localparam int NUM_CODES  = 1 << CODE_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SEG_N-1:0]  seg_t;

    // Code held after reset: the all-off glyph
    localparam code_t BLANK_CODE = code_t'(NUM_CODES - 1);
endpackage

// File: rtl/seg7_code_hold.sv
// Strobed code register.
// Synchronous stand-in for a transparent latch: it loads d on each
// clock edge while load is high and keeps its value otherwise.
// Assumes a synchronous active-low reset, which returns it to RESET_CODE.
module seg7_code_hold
    import seg7_lcd_pkg::*;
#(
    parameter code_t RESET_CODE = BLANK_CODE
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  code_t d,
    output code_t q
);
    code_t held_q;

    // Capture the incoming code while strobed; keep it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= RESET_CODE;
        else if (load)
            held_q <= d;
    end

    assign q = held_q;

    // R3
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

    // R9
    reset_blank_chk: assert property (@(posedge clk)
        !rst_n |=> (q == RESET_CODE));
endmodule

// File: rtl/seg7_glyph_dec.sv
// Glyph decoder: maps each code to its segment-select pattern.
// Bit 0 is segment a and bit 6 is segment g; a 1 means lit.
// Purely combinational, and every code value has a glyph.
module seg7_glyph_dec
    import seg7_lcd_pkg::*;
(
    input  code_t code,
    output seg_t  pattern
);
    // Lookup of the sixteen glyphs: digits, then L P H A dash blank
    always_comb begin
        unique case (code)
            4'd0:    pattern = 7'h3F;
            4'd1:    pattern = 7'h06;
            4'd2:    pattern = 7'h5B;
            4'd3:    pattern = 7'h4F;
            4'd4:    pattern = 7'h66;
            4'd5:    pattern = 7'h6D;
            4'd6:    pattern = 7'h7D;
            4'd7:    pattern = 7'h07;
            4'd8:    pattern = 7'h7F;
            4'd9:    pattern = 7'h6F;
            4'd10:   pattern = 7'h38;
            4'd11:   pattern = 7'h73;
            4'd12:   pattern = 7'h76;
            4'd13:   pattern = 7'h77;
            4'd14:   pattern = 7'h40;
            default: pattern = 7'h00;
        endcase
    end
endmodule

// File: rtl/seg7_polarity_drv.sv
// Polarity stage: XORs each segment select with the display-frequency
// level and forwards that level on the common-electrode output.
// With OUT_REG=1, segments and common share one register stage, so they
// change on the same edge. With OUT_REG=0, the stage is combinational.
module seg7_polarity_drv
    import seg7_lcd_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  seg_t pattern,
    input  logic df,
    output seg_t seg_out,
    output logic com_out
);
    seg_t drive_c;

    // One XOR per segment line
    for (genvar i = 0; i < SEG_N; i++) begin : g_seg
        assign drive_c[i] = pattern[i] ^ df;
    end

    if (OUT_REG) begin : g_reg
        seg_t seg_q;
        logic com_q;

        // Register the segment lines and the common copy together
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_q <= '0;
                com_q <= 1'b0;
            end else begin
                seg_q <= drive_c;
                com_q <= df;
            end
        end

        assign seg_out = seg_q;
        assign com_out = com_q;

        // R8
        com_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (com_out == $past(df)));

        // R5 R6
        polarity_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> ((seg_out ^ {SEG_N{com_out}}) == $past(pattern)));

        // R7
        df_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $stable(pattern) && (df != $past(df)))
            |=> (seg_out == ~$past(seg_out)));
    end else begin : g_comb
        assign seg_out = drive_c;
        assign com_out = df;
    end
endmodule

// File: rtl/seg7_lcd_decoder.sv
// Top level: strobed code register -> glyph decoder -> polarity stage.
// Latency with the default registered output: a code reaches seg_out two
// edges after it is applied with strobe high, and df_in reaches seg_out
// and com_out one edge after it changes.
module seg7_lcd_decoder
    import seg7_lcd_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic             strobe,
    input  logic             df_in,
    output logic [SEG_N-1:0]  seg_out,
    output logic             com_out
);
    code_t held_code;
    seg_t  sel_pattern;

    seg7_code_hold #(.RESET_CODE(BLANK_CODE)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (strobe),
        .d     (code_in),
        .q     (held_code)
    );

    seg7_glyph_dec u_dec (
        .code    (held_code),
        .pattern (sel_pattern)
    );

    seg7_polarity_drv #(.OUT_REG(OUT_REG)) u_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .pattern (sel_pattern),
        .df      (df_in),
        .seg_out (seg_out),
        .com_out (com_out)
    );
endmodule

// File: tb/sim_seg7_lcd_decoder.sv
module sim_seg7_lcd_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] code_in = 4'd0;
    logic       strobe = 1'b0;
    logic       df_in = 1'b0;
    logic [6:0] seg_out;
    logic       com_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    seg7_lcd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .code_in(code_in), .strobe(strobe),
        .df_in(df_in), .seg_out(seg_out), .com_out(com_out)
    );

    // Expected glyphs, written from R1 and R2
    function automatic logic [6:0] want(input logic [3:0] c);
        case (c)
            4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
            4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
            4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
            4'd9: return 7'h6F;  4'd10: return 7'h38; 4'd11: return 7'h73;
            4'd12: return 7'h76; 4'd13: return 7'h77; 4'd14: return 7'h40;
            default: return 7'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Advance one edge; inputs change and outputs are read at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; strobe = 1'b0; df_in = 1'b1; code_in = 4'd8;
        tick(); tick();
        check("R9 seg", {1'b0, seg_out}, 8'h00);
        check("R9 com", {7'b0, com_out}, 8'h00);
        rst_n = 1'b1; df_in = 1'b0;
        tick(); tick();
        check("R9 blank held", {1'b0, seg_out}, 8'h00);
    endtask

    // R1 R2 R3 R5: every code with df low, strobed in
    task automatic t_codes_df_low();
        logic [6:0] seen [16];
        df_in = 1'b0; strobe = 1'b1;
        for (int c = 0; c < 16; c++) begin
            code_in = 4'(c);
            tick(); tick();
            seen[c] = seg_out;
            check(c < 10 ? "R1 digit df low" : "R2 glyph df low",
                  {1'b0, seg_out}, {1'b0, want(4'(c))});
        end
        for (int i = 0; i < 16; i++)
            for (int j = i + 1; j < 16; j++)
                check("R2 distinct", {7'b0, seen[i] == seen[j]}, 8'h00);
    endtask

    // R6: every code with df high
    task automatic t_codes_df_high();
        df_in = 1'b1; strobe = 1'b1;
        for (int c = 0; c < 16; c++) begin
            code_in = 4'(c);
            tick(); tick();
            check("R6 df high", {1'b0, seg_out}, {1'b0, ~want(4'(c))});
        end
    endtask

    // R3: exact two-edge latency of a strobed code
    task automatic t_latency();
        df_in = 1'b0; strobe = 1'b1; code_in = 4'd1;
        tick(); tick();
        code_in = 4'd4;
        tick();
        check("R3 not yet", {1'b0, seg_out}, {1'b0, want(4'd1)});
        tick();
        check("R3 arrived", {1'b0, seg_out}, {1'b0, want(4'd4)});
    endtask

    // R4: with strobe low, code_in changes are ignored
    task automatic t_hold();
        df_in = 1'b0; strobe = 1'b1; code_in = 4'd12;
        tick(); tick();
        strobe = 1'b0;
        for (int k = 0; k < 6; k++) begin
            code_in = 4'(k * 3);
            tick();
            check("R4 hold", {1'b0, seg_out}, {1'b0, want(4'd12)});
        end
        strobe = 1'b1; code_in = 4'd7;
        tick(); tick();
        check("R4 release", {1'b0, seg_out}, {1'b0, want(4'd7)});
    endtask

    // R7 R8: df square wave with a fixed held code
    task automatic t_toggle();
        strobe = 1'b1; code_in = 4'd13; df_in = 1'b0;
        tick(); tick();
        strobe = 1'b0;
        for (int k = 0; k < 8; k++) begin
            df_in = ~df_in;
            tick();
            check("R8 com", {7'b0, com_out}, {7'b0, df_in});
            check("R7 toggle", {1'b0, seg_out}, {1'b0, want(4'd13) ^ {7{df_in}}});
        end
    endtask

    // R3 R7: capture and polarity flip on the same edge
    task automatic t_collision();
        strobe = 1'b1; code_in = 4'd5; df_in = 1'b0;
        tick(); tick();
        code_in = 4'd2; df_in = 1'b1;
        tick();
        check("R7 old glyph new polarity", {1'b0, seg_out}, {1'b0, ~want(4'd5)});
        check("R8 com same edge", {7'b0, com_out}, 8'h01);
        strobe = 1'b0; code_in = 4'd9; df_in = 1'b0;
        tick();
        check("R3 new glyph", {1'b0, seg_out}, {1'b0, want(4'd2)});
        check("R8 com back", {7'b0, com_out}, 8'h00);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_codes_df_low();
        t_codes_df_high();
        t_latency();
        t_hold();
        t_toggle();
        t_collision();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule